// File: doc/BRIEF.md
# Interrupt Pin Request and End-of-Interrupt Tracker

This block keeps the request state of a small set of interrupt input pins and decides when each pin's table entry has to be handed to the delivery logic. Pin changes arrive as events (pin number plus raw level). Each entry's configuration supplies a polarity bit, a trigger mode (edge or level), a mask bit and a vector number. The block turns an event into an effective level, updates the pin's request bit, and schedules a service when the entry needs one.

A service of an unmasked entry raises a delivery request carrying the pin, its vector and its trigger mode. The request stays up until the delivery logic reports completion, with a flag saying whether the interrupt was actually injected. Level-triggered entries that were injected are then held off by an in-service flag. An end-of-interrupt message carrying a vector clears that flag on every entry with a matching vector, and re-services each of those entries that is still requesting. Edge-triggered entries drop their request bit once serviced. Only one delivery is in flight at a time, and waiting services are granted lowest pin first.

Top module: `pin_req_tracker`

## Requirements
- R1: After reset every request bit and every in-service flag is 0 and no delivery is requested.
- R2: An event on pin p computes eff = raw level XOR polarity[p]; eff = 0 clears request bit p, eff = 1 sets it.
- R3: An event with eff = 1 schedules a service of entry p when entry p is edge-mode (trigger bit 0) and its request bit was 0, or when its in-service flag is 0; a level-mode entry (trigger bit 1) with its in-service flag at 1 is not serviced again.
- R4: Servicing an unmasked entry (mask bit 0) raises dlv_req with dlv_pin, dlv_vector and dlv_level taken from that entry, held unchanged until dlv_done; a masked entry (mask bit 1) raises no request.
- R5: When dlv_done arrives with dlv_ok = 1 for a level-mode entry its in-service flag becomes 1; with dlv_ok = 0 it stays 0.
- R6: After an edge-mode entry is serviced, masked or not, its request bit is 0; a level-mode entry keeps its request bit.
- R7: An end-of-interrupt with vector V clears the in-service flag of every entry whose vector equals V, and each such entry that is unmasked with its request bit set is serviced again.
- R8: An event whose pin number is NUM_PINS or above changes no request bit, no in-service flag and starts no delivery.
- R9: At most one delivery is outstanding; when several services wait, the lowest pin number is delivered first.
- R10: When a successful level-mode completion and a matching end-of-interrupt fall in the same cycle, the in-service flag ends at 1 and no re-service follows; when an edge-mode completion and a new eff = 1 event on the same pin fall in the same cycle, the request bit ends at 1 and a new service follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | Pin event strobe |
| irq_pin | input | PIN_W | Pin number of the event |
| irq_level | input | 1 | Raw pin level of the event |
| cfg_mask | input | NUM_PINS | Per-entry mask bit (1 = masked) |
| cfg_pol | input | NUM_PINS | Per-entry polarity bit (1 = active low) |
| cfg_level | input | NUM_PINS | Per-entry trigger mode (1 = level, 0 = edge) |
| cfg_vector | input | NUM_PINS*VEC_W | Per-entry vector, entry i at bits i*VEC_W upward |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_req | output | 1 | Delivery request outstanding |
| dlv_pin | output | IDX_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector being delivered |
| dlv_level | output | 1 | Trigger mode of the entry being delivered |
| dlv_done | input | 1 | Delivery completed this cycle |
| dlv_ok | input | 1 | Completed delivery was injected |
| req_bits | output | NUM_PINS | Per-pin request bits |
| inserv_bits | output | NUM_PINS | Per-pin in-service flags |

## Verification
Two functions can strike the same entry in one cycle: completing its delivery and receiving an end-of-interrupt that matches its vector, or completing an edge-mode delivery while a fresh event arrives on that pin. The bench provokes both by driving dlv_done with dlv_ok together with a matching eoi_vector, and dlv_done together with an eff = 1 event, on the entry currently being delivered. It judges the first by the in-service flag staying at 1 with no further request over the following cycles, and the second by the request bit staying at 1 and a new request for the same pin appearing one cycle later.

// File: rtl/pin_req_pkg.sv
package pin_req_pkg;
  typedef enum logic {
    SVC_IDLE = 1'b0,
    SVC_BUSY = 1'b1
  } svc_state_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM   = 6,
  parameter int IDX_W = 3
) (
  input  logic [NUM-1:0]   req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
  import pin_req_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_found,
  input  logic             pick_masked,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             dlv_done,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             take
);
  svc_state_e       state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic             cur_en;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    take    = (state_q == SVC_IDLE) && pick_found;
    cur_en  = take && !pick_masked;
    if (cur_en) begin
      state_d = SVC_BUSY;
      cur_d   = pick_idx;
    end else if ((state_q == SVC_BUSY) && dlv_done) begin
      state_d = SVC_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SVC_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign busy    = (state_q == SVC_BUSY);
  assign cur_idx = cur_q;

  // R9
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dlv_done) |=> (busy && $stable(cur_idx)));
endmodule

// File: rtl/pin_req_tracker.sv
module pin_req_tracker #(
  parameter int NUM_PINS = 6,
  parameter int PIN_W    = 4,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      irq_valid,
  input  logic [PIN_W-1:0]          irq_pin,
  input  logic                      irq_level,
  input  logic [NUM_PINS-1:0]       cfg_mask,
  input  logic [NUM_PINS-1:0]       cfg_pol,
  input  logic [NUM_PINS-1:0]       cfg_level,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  output logic                      dlv_req,
  output logic [IDX_W-1:0]          dlv_pin,
  output logic [VEC_W-1:0]          dlv_vector,
  output logic                      dlv_level,
  input  logic                      dlv_done,
  input  logic                      dlv_ok,
  output logic [NUM_PINS-1:0]       req_bits,
  output logic [NUM_PINS-1:0]       inserv_bits
);
  logic [VEC_W-1:0]    vec_a [NUM_PINS];
  logic [NUM_PINS-1:0] irr_q, irr_d, rirr_q, rirr_d, pend_q, pend_d;
  logic [NUM_PINS-1:0] hit_evt, eoi_hit, cmpl, set_rirr, trig_evt, pin_en;
  logic                pick_found, pick_masked, busy, take;
  logic [IDX_W-1:0]    pick_idx, cur_idx;
  logic                eff;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_vec
    assign vec_a[g] = cfg_vector[g*VEC_W +: VEC_W];
  end

  prio_pick #(.NUM(NUM_PINS), .IDX_W(IDX_W)) pick_i (
    .req(pend_q), .found(pick_found), .idx(pick_idx)
  );

  assign pick_masked = cfg_mask[pick_idx];

  svc_fsm #(.IDX_W(IDX_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .pick_found(pick_found),
    .pick_masked(pick_masked), .pick_idx(pick_idx), .dlv_done(dlv_done),
    .busy(busy), .cur_idx(cur_idx), .take(take)
  );

  assign eff = irq_level ^ cfg_pol[irq_pin[IDX_W-1:0]];

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      logic serviced;
      hit_evt[i]  = irq_valid && (irq_pin == PIN_W'(i));
      eoi_hit[i]  = eoi_valid && (vec_a[i] == eoi_vector);
      cmpl[i]     = busy && dlv_done && (cur_idx == IDX_W'(i));
      set_rirr[i] = cmpl[i] && dlv_ok && cfg_level[i];
      serviced    = cmpl[i] || (take && pick_masked && (pick_idx == IDX_W'(i)));
      trig_evt[i] = hit_evt[i] && eff &&
                    ((!cfg_level[i] && !irr_q[i]) || !rirr_q[i]);
      // request bit: edge service clears, a same-cycle event wins
      irr_d[i] = irr_q[i];
      if (serviced && !cfg_level[i]) irr_d[i] = 1'b0;
      if (hit_evt[i]) irr_d[i] = eff;
      // in-service flag: completion wins over a same-cycle EOI
      rirr_d[i] = rirr_q[i];
      if (eoi_hit[i]) rirr_d[i] = 1'b0;
      if (set_rirr[i]) rirr_d[i] = 1'b1;
      // pending service
      pend_d[i] = pend_q[i];
      if (take && (pick_idx == IDX_W'(i))) pend_d[i] = 1'b0;
      if (trig_evt[i] ||
          (eoi_hit[i] && !cfg_mask[i] && irr_d[i] && !set_rirr[i]))
        pend_d[i] = 1'b1;
      pin_en[i] = hit_evt[i] || eoi_hit[i] || serviced || take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      rirr_q <= '0;
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (pin_en[i]) begin
          irr_q[i]  <= irr_d[i];
          rirr_q[i] <= rirr_d[i];
          pend_q[i] <= pend_d[i];
        end
      end
    end
  end

  assign dlv_req     = busy;
  assign dlv_pin     = cur_idx;
  assign dlv_vector  = vec_a[cur_idx];
  assign dlv_level   = cfg_level[cur_idx];
  assign req_bits    = irr_q;
  assign inserv_bits = rirr_q;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_req && !dlv_done) |=> (dlv_req && $stable(dlv_pin)));

  // R8
  oor_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && (int'(irq_pin) >= NUM_PINS) && !dlv_done && !eoi_valid && !take)
    |=> ($stable(req_bits) && $stable(inserv_bits)));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    // R5
    rirr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inserv_bits[g] && !$past(inserv_bits[g])) |-> $past(set_rirr[g]));
    // R7
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit[g] && !set_rirr[g]) |=> !inserv_bits[g]);
  end
endmodule

// File: tb/pin_req_tracker_tb_top.sv
module pin_req_tracker_tb_top;
  localparam int N  = 6;
  localparam int PW = 4;
  localparam int VW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_valid, irq_level, eoi_valid, dlv_done, dlv_ok;
  logic [PW-1:0] irq_pin;
  logic [N-1:0] cfg_mask, cfg_pol, cfg_level;
  logic [N*VW-1:0] cfg_vector;
  logic [VW-1:0] eoi_vector;
  logic dlv_req, dlv_level;
  logic [IW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [N-1:0] req_bits, inserv_bits;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pin_req_tracker #(.NUM_PINS(N), .PIN_W(PW), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_pin(irq_pin),
    .irq_level(irq_level), .cfg_mask(cfg_mask), .cfg_pol(cfg_pol),
    .cfg_level(cfg_level), .cfg_vector(cfg_vector), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .dlv_req(dlv_req), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_level(dlv_level), .dlv_done(dlv_done),
    .dlv_ok(dlv_ok), .req_bits(req_bits), .inserv_bits(inserv_bits)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // one clock edge; strobes drop after it, outputs are then sampled
  task automatic tick();
    @(posedge clk);
    #5;
    irq_valid = 1'b0;
    eoi_valid = 1'b0;
    dlv_done  = 1'b0;
    dlv_ok    = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #3;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic ev(input int p, input logic lvl);
    irq_valid = 1'b1;
    irq_pin   = PW'(p);
    irq_level = lvl;
  endtask

  task automatic set_vec(input int p, input logic [VW-1:0] v);
    cfg_vector[p*VW +: VW] = v;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    irq_valid = 0; irq_pin = '0; irq_level = 0; eoi_valid = 0; eoi_vector = '0;
    dlv_done = 0; dlv_ok = 0;
    cfg_mask = '1; cfg_pol = '0; cfg_level = '0;
    for (int j = 0; j < N; j++) set_vec(j, VW'(8'hF0 + j));
    do_reset();
    chk("R1 req_bits", 32'(req_bits), 0);
    chk("R1 inserv_bits", 32'(inserv_bits), 0);
    chk("R1 dlv_req", 32'(dlv_req), 0);

    // sweep: pin x polarity x trigger x mask
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic pol, lvl, msk;
        logic [VW-1:0] v;
        pol = c[2]; lvl = c[1]; msk = c[0];
        v = VW'(8'h20 + p * 8 + c);
        cfg_mask = '1; cfg_pol = '0; cfg_level = '0;
        for (int j = 0; j < N; j++) set_vec(j, VW'(8'hF0 + j));
        cfg_mask[p] = msk; cfg_pol[p] = pol; cfg_level[p] = lvl; set_vec(p, v);
        do_reset();
        ev(p, ~pol);
        tick();
        chk("R2 eff high sets", 32'(req_bits), 32'(1 << p));
        chk("R4 no req yet", 32'(dlv_req), 0);
        tick();
        if (msk) begin
          chk("R4 masked no req", 32'(dlv_req), 0);
          chk("R6 masked service", 32'(req_bits[p]), 32'(lvl));
          tick();
          chk("R4 masked still idle", 32'(dlv_req), 0);
        end else begin
          chk("R4 req", 32'(dlv_req), 1);
          chk("R4 pin", 32'(dlv_pin), 32'(p));
          chk("R4 vector", 32'(dlv_vector), 32'(v));
          chk("R4 trig", 32'(dlv_level), 32'(lvl));
          tick();
          chk("R4 held", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(p)}));
          dlv_done = 1; dlv_ok = 1;
          tick();
          chk("R4 released", 32'(dlv_req), 0);
          chk("R5 inserv set", 32'(inserv_bits[p]), 32'(lvl));
          chk("R6 edge clears", 32'(req_bits[p]), 32'(lvl));
          if (lvl) begin
            ev(p, ~pol);
            tick(); tick();
            chk("R3 held off", 32'(dlv_req), 0);
            eoi_valid = 1; eoi_vector = v;
            tick();
            chk("R7 inserv cleared", 32'(inserv_bits[p]), 0);
            tick();
            chk("R7 reservice", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(p)}));
            dlv_done = 1; dlv_ok = 0;
            tick();
            chk("R5 not injected", 32'(inserv_bits[p]), 0);
          end else begin
            ev(p, ~pol);
            tick(); tick();
            chk("R3 edge retrigger", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(p)}));
            dlv_done = 1; dlv_ok = 1;
            tick();
          end
        end
        ev(p, pol);
        tick();
        chk("R2 eff low clears", 32'(req_bits[p]), 0);
      end
    end

    // out-of-range pin numbers
    cfg_mask = '0; cfg_pol = '0; cfg_level = '0;
    do_reset();
    for (int q = N; q < (1 << PW); q++) begin
      ev(q, 1'b1);
      tick();
      chk("R8 oor req_bits", 32'(req_bits), 0);
      tick();
      chk("R8 oor no req", 32'(dlv_req), 0);
    end

    // arbitration: arrival order 5,2,4 then EOI re-service 2,4,5
    cfg_mask = '0; cfg_pol = '0; cfg_level = '1;
    for (int j = 0; j < N; j++) set_vec(j, 8'h55);
    do_reset();
    ev(5, 1); tick();
    ev(2, 1); tick();
    ev(4, 1); tick();
    for (int k = 0; k < 3; k++) begin
      int e;
      e = (k == 0) ? 5 : (k == 1) ? 2 : 4;
      chk("R9 order first pass", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(e)}));
      dlv_done = 1; dlv_ok = 1;
      tick();
      chk("R9 single outstanding", 32'(dlv_req), 0);
      tick();
    end
    chk("R5 all in service", 32'(inserv_bits), 32'(6'b110100));
    eoi_valid = 1; eoi_vector = 8'h55;
    tick();
    chk("R7 broadcast clear", 32'(inserv_bits), 0);
    tick();
    for (int k = 0; k < 3; k++) begin
      int e;
      e = (k == 0) ? 2 : (k == 1) ? 4 : 5;
      chk("R9 order eoi pass", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(e)}));
      dlv_done = 1; dlv_ok = 1;
      tick(); tick();
    end

    // same-cycle: level completion with matching EOI
    cfg_mask = '0; cfg_pol = '0; cfg_level = '0; cfg_level[1] = 1;
    for (int j = 0; j < N; j++) set_vec(j, VW'(8'h30 + j));
    do_reset();
    ev(1, 1); tick(); tick();
    chk("R10 level busy", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(1)}));
    dlv_done = 1; dlv_ok = 1; eoi_valid = 1; eoi_vector = 8'h31;
    tick();
    chk("R10 inserv wins", 32'(inserv_bits[1]), 1);
    tick();
    chk("R10 no reservice", 32'(dlv_req), 0);
    tick();
    chk("R10 still idle", 32'(dlv_req), 0);

    // same-cycle: edge completion with new event
    ev(3, 1); tick(); tick();
    chk("R10 edge busy", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(3)}));
    dlv_done = 1; dlv_ok = 1; ev(3, 1);
    tick();
    chk("R10 edge req kept", 32'(req_bits[3]), 1);
    tick();
    chk("R10 edge reservice", 32'({dlv_req, dlv_pin}), 32'({1'b1, IW'(3)}));
    dlv_done = 1; dlv_ok = 1;
    tick();
    chk("R6 edge cleared", 32'(req_bits[3]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule